// File: doc/BRIEF.md
# Dual-Output Serial Pattern Recognizer

This block watches a single serial data bit that is sampled on every rising clock edge. It raises two flags from one Moore state machine. The pair flag is high while the two most recently sampled bits were both zero. The triple flag is high while the three most recently sampled bits were a one followed by two zeros, with the one being the oldest. Occurrences may overlap, and both flags are tracked at the same time. A long run of zeros therefore keeps the pair flag high on every cycle. The triple flag is high only on the cycle that follows the first two zeros after a one.

The flags are decoded from the registered state alone, so they change only just after a rising clock edge. They never follow the data input directly. An active-high asynchronous reset returns the machine to its empty-history state. After reset the pair flag needs at least two sampled bits before it can rise, and the triple flag needs at least three. The serial input must already be synchronous to the clock.

Top module: `patRecog`

## Requirements
- R1: While `rstIn` is high, both flags are low. The reset takes effect at once, without waiting for a clock edge.
- R2: After a rising edge, `pairFlag` is 1 exactly when the last two bits sampled since reset were 0 and then 0.
- R3: After a rising edge, `tripleFlag` is 1 exactly when the last three bits sampled since reset were 1, 0, 0 in that order, where 1 is the oldest.
- R4: `pairFlag` stays 0 until at least two bits have been sampled after reset is released.
- R5: `tripleFlag` stays 0 until at least three bits have been sampled after reset is released. In particular, a reset followed by 0, 0 gives pair high and triple low.
- R6: Detection overlaps. For the input 1,0,0,0, `pairFlag` is high after both the third and the fourth bit, and `tripleFlag` is high after the third bit only.
- R7: Sampling a 1 on `dataIn` drives both flags to 0 after that edge.
- R8: `tripleFlag` is never 1 while `pairFlag` is 0.
- R9: The flags depend only on the registered state. A change on `dataIn` between clock edges leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The data bit is sampled on its rising edge. |
| rstIn | input | 1 | Asynchronous reset, active high. |
| dataIn | input | 1 | Serial data bit, synchronous to `clk`. |
| pairFlag | output | 1 | High when the last two bits were 0, 0. |
| tripleFlag | output | 1 | High when the last three bits were 1, 0, 0. |

## Verification
On every cycle, the bound checker compares both flags against its own short bit history and its count of bits sampled since reset. This covers exact detection, the warm-up limits after reset, clearing on a 1, and the triple flag implying the pair flag. The other behaviours are shown only by the bench's scenarios: reset forcing the flags low between clock edges, flag stability while the data input toggles mid-cycle, and the overlapping 1,0,0,0 sequence. The bench also runs a long random stream weighted toward zeros so that both patterns occur often.

// File: rtl/patRecogPkg.sv
package patRecogPkg;

  // History classes the recognizer must tell apart
  typedef enum logic [2:0] {
    ST_EMPTY   = 3'd0,  // nothing sampled since reset
    ST_ZERO    = 3'd1,  // single 0, no 1 before it
    ST_ONE     = 3'd2,  // last bit 1
    ST_ONEZERO = 3'd3,  // last bits 1,0
    ST_HIT100  = 3'd4,  // last bits 1,0,0
    ST_ZEROS   = 3'd5   // last bits 0,0 with no 1 right before them
  } recogState_t;

  // Strobes from the control section to the output datapath
  typedef struct packed {
    logic pairHit;
    logic tripleHit;
  } detectStrobes_t;

endpackage

// File: rtl/patRecogCtrl.sv
module patRecogCtrl
  import patRecogPkg::*;
(
  input  logic           clk,
  input  logic           rstIn,
  input  logic           dataIn,
  output detectStrobes_t strobes
);

  recogState_t presentState;
  recogState_t nextState;

  // Next state from present state and input only
  always_comb begin
    nextState = ST_EMPTY;
    if (dataIn) begin
      nextState = ST_ONE;
    end else begin
      unique case (presentState)
        ST_EMPTY:   nextState = ST_ZERO;
        ST_ZERO:    nextState = ST_ZEROS;
        ST_ONE:     nextState = ST_ONEZERO;
        ST_ONEZERO: nextState = ST_HIT100;
        ST_HIT100:  nextState = ST_ZEROS;
        ST_ZEROS:   nextState = ST_ZEROS;
        default:    nextState = ST_EMPTY;
      endcase
    end
  end

  always_ff @(posedge clk or posedge rstIn) begin
    if (rstIn) presentState <= ST_EMPTY;
    else       presentState <= nextState;
  end

  // Moore decode: strobes depend on the registered state alone
  always_comb begin
    strobes.pairHit   = (presentState == ST_HIT100) || (presentState == ST_ZEROS);
    strobes.tripleHit = (presentState == ST_HIT100);
  end

endmodule

// File: rtl/patRecogDatapath.sv
module patRecogDatapath
  import patRecogPkg::*;
(
  input  detectStrobes_t strobes,
  output logic           pairFlag,
  output logic           tripleFlag
);

  assign pairFlag   = strobes.pairHit;
  assign tripleFlag = strobes.tripleHit;

endmodule

// File: rtl/patRecog.sv
module patRecog
  import patRecogPkg::*;
(
  input  logic clk,
  input  logic rstIn,
  input  logic dataIn,
  output logic pairFlag,
  output logic tripleFlag
);

  detectStrobes_t strobes;

  patRecogCtrl uCtrl (
    .clk     (clk),
    .rstIn   (rstIn),
    .dataIn  (dataIn),
    .strobes (strobes)
  );

  patRecogDatapath uDp (
    .strobes    (strobes),
    .pairFlag   (pairFlag),
    .tripleFlag (tripleFlag)
  );

endmodule

// File: rtl/patRecogChecker.sv
module patRecogChecker (
  input logic clk,
  input logic rstIn,
  input logic dataIn,
  input logic pairFlag,
  input logic tripleFlag
);

  logic [2:0] histBits;   // histBits[0] is the newest sample
  logic [1:0] fillCount;  // samples since reset, saturating at 3

  always_ff @(posedge clk or posedge rstIn) begin
    if (rstIn) begin
      histBits  <= 3'b000;
      fillCount <= 2'd0;
    end else begin
      histBits <= {histBits[1:0], dataIn};
      if (fillCount != 2'd3) fillCount <= fillCount + 2'd1;
    end
  end

  assert_pair_exact_R2: assert property (@(posedge clk) disable iff (rstIn)
    pairFlag == ((fillCount >= 2'd2) && (histBits[1:0] == 2'b00)));

  assert_triple_exact_R3: assert property (@(posedge clk) disable iff (rstIn)
    tripleFlag == ((fillCount == 2'd3) && (histBits == 3'b100)));

  assert_pair_warmup_R4: assert property (@(posedge clk) disable iff (rstIn)
    (fillCount < 2'd2) |-> !pairFlag);

  assert_triple_warmup_R5: assert property (@(posedge clk) disable iff (rstIn)
    (fillCount < 2'd3) |-> !tripleFlag);

  assert_one_clears_R7: assert property (@(posedge clk) disable iff (rstIn)
    dataIn |=> (!pairFlag && !tripleFlag));

  assert_triple_implies_pair_R8: assert property (@(posedge clk) disable iff (rstIn)
    tripleFlag |-> pairFlag);

endmodule

bind patRecog patRecogChecker uChk (
  .clk        (clk),
  .rstIn      (rstIn),
  .dataIn     (dataIn),
  .pairFlag   (pairFlag),
  .tripleFlag (tripleFlag)
);

// File: tb/patRecog_test.sv
module patRecog_test;

  localparam int PERIOD = 10;
  localparam int RANDOM_BITS = 3000;

  logic clk = 1'b0;
  logic rstIn = 1'b1;
  logic dataIn = 1'b0;
  logic pairFlag, tripleFlag;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [2:0] modelHist = 3'b000;
  int modelFill = 0;

  patRecog uut (
    .clk        (clk),
    .rstIn      (rstIn),
    .dataIn     (dataIn),
    .pairFlag   (pairFlag),
    .tripleFlag (tripleFlag)
  );

  always #(PERIOD / 2) clk = ~clk;

  function automatic logic expPair(input logic [2:0] h, input int f);
    return (f >= 2) && (h[1:0] == 2'b00);
  endfunction

  function automatic logic expTriple(input logic [2:0] h, input int f);
    return (f >= 3) && (h == 3'b100);
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Drive one bit at a falling edge, let it be sampled, check at the next falling edge
  task automatic pushBit(input logic b, input string req);
    dataIn = b;
    modelHist = {modelHist[1:0], b};
    modelFill++;
    @(posedge clk);
    @(negedge clk);
    chk(req, "pairFlag", pairFlag, expPair(modelHist, modelFill));
    chk(req, "tripleFlag", tripleFlag, expTriple(modelHist, modelFill));
  endtask

  task automatic doReset();
    rstIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rstIn = 1'b0;
    modelHist = 3'b000;
    modelFill = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: flags low while reset is held, even with zeros on the input
    @(negedge clk);
    @(negedge clk);
    chk("R1", "pairFlag in reset", pairFlag, 1'b0);
    chk("R1", "tripleFlag in reset", tripleFlag, 1'b0);
    doReset();

    // R4, R5: warm-up; R2 pair after 0,0 with the triple still low
    pushBit(1'b0, "R4");
    chk("R4", "pairFlag after one bit", pairFlag, 1'b0);
    pushBit(1'b0, "R2");
    chk("R2", "pairFlag after 0,0", pairFlag, 1'b1);
    chk("R5", "tripleFlag after only 0,0", tripleFlag, 1'b0);

    // R9: toggling the input mid-cycle leaves the flags alone
    dataIn = 1'b1;
    #1;
    chk("R9", "pairFlag after mid-cycle toggle", pairFlag, 1'b1);
    chk("R9", "tripleFlag after mid-cycle toggle", tripleFlag, 1'b0);
    dataIn = 1'b0;

    // R1: asynchronous reset drops the flags with no clock edge
    #1;
    rstIn = 1'b1;
    #1;
    chk("R1", "pairFlag on async reset", pairFlag, 1'b0);
    @(negedge clk);
    rstIn = 1'b0;
    modelHist = 3'b000;
    modelFill = 0;

    // R3, R6: 1,0,0,0 overlap
    pushBit(1'b1, "R7");
    pushBit(1'b0, "R6");
    pushBit(1'b0, "R3");
    chk("R3", "tripleFlag after 1,0,0", tripleFlag, 1'b1);
    chk("R6", "pairFlag after 1,0,0", pairFlag, 1'b1);
    pushBit(1'b0, "R6");
    chk("R6", "tripleFlag after 1,0,0,0", tripleFlag, 1'b0);
    chk("R6", "pairFlag after 1,0,0,0", pairFlag, 1'b1);

    // R7: a 1 clears both flags
    pushBit(1'b1, "R7");
    chk("R7", "pairFlag after a 1", pairFlag, 1'b0);
    pushBit(1'b0, "R7");
    pushBit(1'b0, "R3");
    chk("R3", "tripleFlag after second 1,0,0", tripleFlag, 1'b1);
    pushBit(1'b1, "R7");
    chk("R7", "tripleFlag after a 1", tripleFlag, 1'b0);

    // Reset then 1,0,0 right away: triple on the third bit (R5 limit met)
    doReset();
    pushBit(1'b1, "R5");
    pushBit(1'b0, "R5");
    pushBit(1'b0, "R3");
    chk("R3", "tripleFlag after reset then 1,0,0", tripleFlag, 1'b1);

    // Random stream weighted toward zeros; R8 checked alongside
    for (int i = 0; i < RANDOM_BITS; i++) begin
      pushBit(($urandom % 3) == 0, "R2");
      chk("R8", "triple implies pair", !tripleFlag || pairFlag, 1'b1);
      if (($urandom % 500) == 0) doReset();
    end

    finishRun();
  end

endmodule